// File: doc/BRIEF.md
# Core Event Counter Bank

A bank of ten 48-bit event counters that watches a processor core. Counter 0 counts clock cycles and counter 1 counts retired instructions; counters 2 to 9 each pick one of 256 event lines through an 8-bit selector. Every counter has its own count enable and two privilege qualifiers, one for user mode and one for kernel mode. It advances by one in a cycle only when it is enabled, its chosen event line is high, and the qualifier for the current privilege level is set.

An increment that sets bit 47 marks an overflow. The overflow is latched in a sticky status bit. An interrupt line is raised while the interrupt mode is not OFF and any latched overflow has its interrupt enable set. Software reaches all state through a plain synchronous register port. Writes are single-cycle strobes and reads are combinational from the address. No part of this block is a data stream, so there is no valid/ready handshake and no back-pressure.

Register map (5-bit word address, 48-bit data): 0 control, 1 privilege filter, 2 selector word A, 3 selector word B, 4 overflow status, 16+i counter i.

Top module: `pmc_bank`

## Requirements
- R1: After reset, every counter, the control, filter and both selector registers, and the status register read 0, and `irq_o` is 0.
- R2: Counter 0 counts `cyc_i` and counter 1 counts `inst_i`. Neither counter is affected by `evt_i` or by the selector registers.
- R3: Counter i in the range 2 to 5 uses selector word A bits [(i-2)*8 +: 8]. Counter i in the range 6 to 9 uses selector word B bits [(i-6)*8 +: 8]. The counter advances in each cycle that `evt_i[selector]` is high.
- R4: The count enable for counter i (i<8) is control bit i, and for counter 8 or 9 it is control bit 16+(i-8). A disabled counter holds its value.
- R5: The user qualifier for counter i is filter bit i (i<8) or bit 16+(i-8). The kernel qualifier is filter bit 8+i (i<8) or bit 18+(i-8). With `priv_kernel_i`=1 the kernel qualifier gates counting, and with 0 the user qualifier does.
- R6: Status bit i is set only by an increment of counter i that changes bit 47 from 0 to 1. A software write of any value, and a wrap from all ones to zero, set nothing. Counting continues modulo 2^48.
- R7: Status bits are sticky. Writing address 4 clears the bits written as 1 and leaves the rest. If a new overflow arrives in the same cycle as its clear, the overflow wins.
- R8: `irq_o` = (mode != OFF) AND any (status[i] AND ienable[i]). The mode is control bits [21:20], with 0 = OFF, 1 = fast, 2 = standard and 3 = reserved (all non-zero codes drive the line). The interrupt enable for counter i is control bit 8+i (i<8) or bit 18+(i-8).
- R9: Control bit 23 is the interrupt-active flag. Hardware sets it at every clock edge where `irq_o` is 1. A control write loads it from the written data, so writing 0 clears it, including when no overflow is pending.
- R10: Counter i is read and written at address 16+i. A write takes priority over an increment at the same edge.
- R11: Control, filter and selector registers read back the values last written to their implemented bits, with unimplemented bits reading 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_i | input | 1 | Cycle event for counter 0 |
| inst_i | input | 1 | Retired-instruction event for counter 1 |
| evt_i | input | 256 | Selectable event lines |
| priv_kernel_i | input | 1 | 1 = core in kernel mode, 0 = user mode |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register word address |
| reg_wdata_i | input | 48 | Register write data |
| reg_rdata_o | output | 48 | Register read data, combinational from address |
| irq_o | output | 1 | Overflow interrupt |

## Verification
The in-RTL assertions check on every cycle that:
- a counter write lands regardless of events;
- an idle counter stays still;
- a flagged overflow leaves bit 47 set;
- status bits never rise without an overflow and never fall without a clear;
- the active flag follows an asserted interrupt.

The bench scenarios are needed to show behaviours that no single-cycle property captures. These are the selector field positions (swept over all 256 selector codes), the split enable and qualifier layouts, and the exact count deltas. They also cover the interrupt gating by mode and by the high-group enables, the wrap that must not flag, and the simultaneous clear-and-set race.

// File: rtl/pmc_pkg.sv
`timescale 1ns/1ps
package pmc_pkg;
  localparam int NUM_CTR    = 10;
  localparam int LO_GROUP   = 8;

  localparam int A_CTRL     = 0;
  localparam int A_FILT     = 1;
  localparam int A_ESEL0    = 2;
  localparam int A_ESEL1    = 3;
  localparam int A_STAT     = 4;
  localparam int A_CTR_BASE = 16;

  localparam int CTL_EN_LO  = 0;
  localparam int CTL_IE_LO  = 8;
  localparam int CTL_EN_HI  = 16;
  localparam int CTL_IE_HI  = 18;
  localparam int CTL_MODE   = 20;
  localparam int CTL_ACT    = 23;
  localparam int CTL_W      = 22;
  localparam int CTL_RD_W   = 24;

  localparam int FLT_U_LO   = 0;
  localparam int FLT_K_LO   = 8;
  localparam int FLT_U_HI   = 16;
  localparam int FLT_K_HI   = 18;
  localparam int FLT_W      = 20;

  typedef enum logic [1:0] {
    IRQ_OFF  = 2'd0,
    IRQ_FAST = 2'd1,
    IRQ_STD  = 2'd2,
    IRQ_RSVD = 2'd3
  } irq_mode_e;

  function automatic int grp_bit(input int lo_base, input int hi_base, input int idx);
    return (idx < LO_GROUP) ? lo_base + idx : hi_base + idx - LO_GROUP;
  endfunction
endpackage

// File: rtl/pmc_counter.sv
`timescale 1ns/1ps
module pmc_counter #(
  parameter int CTR_W   = 48,
  parameter int OVF_BIT = CTR_W - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  input  logic             wr_en_i,
  input  logic [CTR_W-1:0] wr_data_i,
  output logic [CTR_W-1:0] value_o,
  output logic             ovf_o
);
  logic [CTR_W-1:0] val_q;
  logic [CTR_W-1:0] val_inc;

  assign val_inc = val_q + CTR_W'(1);
  assign value_o = val_q;
  // flag only a 0->1 transition of the overflow bit caused by counting
  assign ovf_o   = inc_i && !wr_en_i && !val_q[OVF_BIT] && val_inc[OVF_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n)       val_q <= '0;
    else if (wr_en_i) val_q <= wr_data_i;
    else if (inc_i)   val_q <= val_inc;
  end

  AST_WR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> (val_q == $past(wr_data_i)));                      // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en_i && !inc_i) |=> $stable(val_q));                      // R4
  AST_OVF_BIT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |=> val_q[OVF_BIT]);                                     // R6
endmodule

// File: rtl/pmc_ctrl.sv
`timescale 1ns/1ps
module pmc_ctrl
  import pmc_pkg::*;
#(
  parameter int EVT_W  = 8,
  parameter int ADDR_W = 5,
  localparam int ESEL_W = 4 * EVT_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [ESEL_W-1:0]   wdata_i,
  input  logic [NUM_CTR-1:0]  ovf_i,
  output logic [NUM_CTR-1:0]  cnt_en_o,
  output logic [NUM_CTR-1:0]  usr_o,
  output logic [NUM_CTR-1:0]  krn_o,
  output logic [2*ESEL_W-1:0] esel_o,
  output logic [NUM_CTR-1:0]  status_o,
  output logic [CTL_RD_W-1:0] ctrl_rd_o,
  output logic [FLT_W-1:0]    filt_rd_o,
  output logic                irq_o
);
  logic [CTL_W-1:0]   ctrl_q;
  logic               act_q;
  logic [FLT_W-1:0]   filt_q;
  logic [ESEL_W-1:0]  esel0_q, esel1_q;
  logic [NUM_CTR-1:0] status_q;
  logic [NUM_CTR-1:0] ien;
  logic [NUM_CTR-1:0] clr;
  logic               ctrl_wr, filt_wr, esel0_wr, esel1_wr, stat_wr;
  irq_mode_e          mode;

  assign ctrl_wr  = we_i && (addr_i == ADDR_W'(A_CTRL));
  assign filt_wr  = we_i && (addr_i == ADDR_W'(A_FILT));
  assign esel0_wr = we_i && (addr_i == ADDR_W'(A_ESEL0));
  assign esel1_wr = we_i && (addr_i == ADDR_W'(A_ESEL1));
  assign stat_wr  = we_i && (addr_i == ADDR_W'(A_STAT));
  assign clr      = stat_wr ? wdata_i[NUM_CTR-1:0] : '0;
  assign mode     = irq_mode_e'(ctrl_q[CTL_MODE +: 2]);

  always_comb begin
    for (int i = 0; i < NUM_CTR; i++) begin
      cnt_en_o[i] = ctrl_q[grp_bit(CTL_EN_LO, CTL_EN_HI, i)];
      ien[i]      = ctrl_q[grp_bit(CTL_IE_LO, CTL_IE_HI, i)];
      usr_o[i]    = filt_q[grp_bit(FLT_U_LO, FLT_U_HI, i)];
      krn_o[i]    = filt_q[grp_bit(FLT_K_LO, FLT_K_HI, i)];
    end
  end

  assign irq_o     = (mode != IRQ_OFF) && (|(status_q & ien));
  assign esel_o    = {esel1_q, esel0_q};
  assign status_o  = status_q;
  assign ctrl_rd_o = {act_q, 1'b0, ctrl_q};
  assign filt_rd_o = filt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      act_q    <= 1'b0;
      filt_q   <= '0;
      esel0_q  <= '0;
      esel1_q  <= '0;
      status_q <= '0;
    end else begin
      if (ctrl_wr) begin
        ctrl_q <= wdata_i[CTL_W-1:0];
        act_q  <= wdata_i[CTL_ACT];
      end else if (irq_o) begin
        act_q  <= 1'b1;
      end
      if (filt_wr)  filt_q  <= wdata_i[FLT_W-1:0];
      if (esel0_wr) esel0_q <= wdata_i;
      if (esel1_wr) esel1_q <= wdata_i;
      status_q <= (status_q & ~clr) | ovf_i;
    end
  end

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_wr |=> ((status_q & $past(status_q)) == $past(status_q)));       // R7
  AST_NO_SPURIOUS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_i == '0) |=> ((status_q & ~$past(status_q)) == '0));             // R6
  AST_ACTIVE_FOLLOWS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !ctrl_wr) |=> act_q);                                        // R9
endmodule

// File: rtl/pmc_bank.sv
`timescale 1ns/1ps
module pmc_bank
  import pmc_pkg::*;
#(
  parameter int CTR_W  = 48,
  parameter int EVT_W  = 8,
  parameter int ADDR_W = 5,
  localparam int NUM_EVT = 1 << EVT_W,
  localparam int ESEL_W  = 4 * EVT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cyc_i,
  input  logic               inst_i,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               priv_kernel_i,
  input  logic               reg_we_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [CTR_W-1:0]   reg_wdata_i,
  output logic [CTR_W-1:0]   reg_rdata_o,
  output logic               irq_o
);
  localparam int OVF_BIT = CTR_W - 1;

  logic [NUM_CTR-1:0]  cnt_en, usr, krn, status, inc, ovf, ctr_wr;
  logic [2*ESEL_W-1:0] esel_w;
  logic [CTL_RD_W-1:0] ctrl_rd;
  logic [FLT_W-1:0]    filt_rd;
  logic [CTR_W-1:0]    ctr_val [NUM_CTR];

  pmc_ctrl #(.EVT_W(EVT_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .we_i     (reg_we_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i[ESEL_W-1:0]),
    .ovf_i    (ovf),
    .cnt_en_o (cnt_en),
    .usr_o    (usr),
    .krn_o    (krn),
    .esel_o   (esel_w),
    .status_o (status),
    .ctrl_rd_o(ctrl_rd),
    .filt_rd_o(filt_rd),
    .irq_o    (irq_o)
  );

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    logic hit;
    if (i == 0) begin : g_cyc
      assign hit = cyc_i;
    end else if (i == 1) begin : g_inst
      assign hit = inst_i;
    end else begin : g_sel
      logic [EVT_W-1:0] sel;
      // word A holds counters 2..5, word B counters 6..9; concatenation keeps (i-2)*EVT_W
      assign sel = esel_w[(i-2)*EVT_W +: EVT_W];
      assign hit = evt_i[sel];
    end
    assign inc[i]    = hit && cnt_en[i] && (priv_kernel_i ? krn[i] : usr[i]);
    assign ctr_wr[i] = reg_we_i && (reg_addr_i == ADDR_W'(A_CTR_BASE + i));

    pmc_counter #(.CTR_W(CTR_W), .OVF_BIT(OVF_BIT)) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .inc_i    (inc[i]),
      .wr_en_i  (ctr_wr[i]),
      .wr_data_i(reg_wdata_i),
      .value_o  (ctr_val[i]),
      .ovf_o    (ovf[i])
    );
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == ADDR_W'(A_CTRL))  reg_rdata_o = CTR_W'(ctrl_rd);
    if (reg_addr_i == ADDR_W'(A_FILT))  reg_rdata_o = CTR_W'(filt_rd);
    if (reg_addr_i == ADDR_W'(A_ESEL0)) reg_rdata_o = CTR_W'(esel_w[ESEL_W-1:0]);
    if (reg_addr_i == ADDR_W'(A_ESEL1)) reg_rdata_o = CTR_W'(esel_w[2*ESEL_W-1:ESEL_W]);
    if (reg_addr_i == ADDR_W'(A_STAT))  reg_rdata_o = CTR_W'(status);
    for (int i = 0; i < NUM_CTR; i++) begin
      if (reg_addr_i == ADDR_W'(A_CTR_BASE + i)) reg_rdata_o = ctr_val[i];
    end
  end
endmodule

// File: tb/tb_pmc_bank.sv
`timescale 1ns/1ps
module tb_pmc_bank;
  localparam int CW = 48;
  localparam int NE = 256;
  localparam int AW = 5;
  localparam logic [CW-1:0] HALF = 48'h8000_0000_0000;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          cyc = 1'b0, inst = 1'b0, priv = 1'b0, we = 1'b0;
  logic [NE-1:0] evt = '0;
  logic [AW-1:0] addr = '0;
  logic [CW-1:0] wdata = '0;
  logic [CW-1:0] rdata;
  logic          irq;

  always #2.5 clk = ~clk;

  pmc_bank dut (
    .clk(clk), .rst_n(rst_n), .cyc_i(cyc), .inst_i(inst), .evt_i(evt),
    .priv_kernel_i(priv), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  logic [CW-1:0] base [10];
  logic [CW-1:0] v;

  task automatic chk(input string tag, input logic [CW-1:0] got, input logic [CW-1:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [CW-1:0] d);
    @(negedge clk); we = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [CW-1:0] d);
    addr = AW'(a); #0.5; d = rdata;
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [CW-1:0] ctl(input logic [9:0] en, input logic [9:0] ie,
                                         input logic [1:0] md, input logic act);
    logic [CW-1:0] r = '0;
    r[7:0] = en[7:0]; r[15:8] = ie[7:0]; r[17:16] = en[9:8]; r[19:18] = ie[9:8];
    r[21:20] = md; r[23] = act;
    return r;
  endfunction

  function automatic logic [CW-1:0] flt(input logic [9:0] u, input logic [9:0] k);
    logic [CW-1:0] r = '0;
    r[7:0] = u[7:0]; r[15:8] = k[7:0]; r[17:16] = u[9:8]; r[19:18] = k[9:8];
    return r;
  endfunction

  task automatic snap();
    for (int i = 0; i < 10; i++) rd(16 + i, base[i]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    hold(4);
    rst_n = 1'b1;
    // R1 reset state
    for (int a = 0; a < 5; a++) begin rd(a, v); chk("R1 reg", v, '0); end
    for (int i = 0; i < 10; i++) begin rd(16 + i, v); chk("R1 counter", v, '0); end
    chk("R1 irq", {47'd0, irq}, '0);

    // R11 readback
    wr(0, ctl(10'h3ff, 10'h000, 2'd0, 1'b0));
    wr(1, flt(10'h3ff, 10'h3ff));
    rd(0, v); chk("R11 ctrl", v, ctl(10'h3ff, 10'h000, 2'd0, 1'b0));
    rd(1, v); chk("R11 filt", v, flt(10'h3ff, 10'h3ff));
    wr(2, 48'hFFFF_A1B2_C3D4); rd(2, v); chk("R11 esel A", v, 48'h0000_A1B2_C3D4);
    wr(3, 48'h0000_5566_7788); rd(3, v); chk("R11 esel B", v, 48'h0000_5566_7788);
    wr(2, '0); wr(3, '0);

    // R2 fixed counters
    snap();
    evt = '1; cyc = 1'b1; inst = 1'b1; hold(2); inst = 1'b0; hold(3); cyc = 1'b0; evt = '0;
    rd(16, v); chk("R2 cycles", v, base[0] + 5);
    rd(17, v); chk("R2 instructions", v, base[1] + 2);
    snap();
    evt = '1; hold(4); evt = '0;
    rd(16, v); chk("R2 c0 ignores evt", v, base[0]);
    rd(17, v); chk("R2 c1 ignores evt", v, base[1]);

    // R3 sweep of every selector code on every selectable counter
    for (int s = 0; s < 256; s++) begin
      wr(2, {16'd0, {4{8'(s)}}});
      wr(3, {16'd0, {4{8'(s)}}});
      snap();
      evt = '0; evt[s] = 1'b1; hold(3);
      evt = '1; evt[s] = 1'b0; hold(2);
      evt = '0;
      for (int i = 2; i < 10; i++) begin rd(16 + i, v); chk("R3 sweep", v, base[i] + 3); end
    end
    // R3 distinct selectors: field positions
    for (int r = 0; r < 4; r++) begin
      logic [7:0] sl [10];
      for (int i = 2; i < 10; i++) sl[i] = 8'(r * 61 + 29 * i);
      wr(2, {16'd0, sl[5], sl[4], sl[3], sl[2]});
      wr(3, {16'd0, sl[9], sl[8], sl[7], sl[6]});
      snap();
      for (int i = 2; i < 10; i++) begin
        evt = '0; evt[sl[i]] = 1'b1; hold(i);
      end
      evt = '0;
      for (int i = 2; i < 10; i++) begin rd(16 + i, v); chk("R3 field position", v, base[i] + CW'(i)); end
    end

    // R4 enable sweep
    for (int i = 0; i < 10; i++) begin
      wr(0, ctl(10'h3ff & ~(10'd1 << i), 10'h000, 2'd0, 1'b0));
      snap();
      evt = '1; cyc = 1'b1; inst = 1'b1; hold(4); evt = '0; cyc = 1'b0; inst = 1'b0;
      for (int j = 0; j < 10; j++) begin
        rd(16 + j, v); chk("R4 enable", v, base[j] + ((j == i) ? 0 : 4));
      end
    end
    wr(0, ctl(10'h3ff, 10'h000, 2'd0, 1'b0));

    // R5 privilege qualifiers
    for (int i = 0; i < 10; i++) begin
      for (int f = 0; f < 4; f++) begin
        for (int p = 0; p < 2; p++) begin
          logic [9:0] um, km;
          um = 10'h3ff; km = 10'h3ff;
          um[i] = f[0]; km[i] = f[1];
          wr(1, flt(um, km));
          priv = p[0];
          snap();
          evt = '1; cyc = 1'b1; inst = 1'b1; hold(3); evt = '0; cyc = 1'b0; inst = 1'b0;
          rd(16 + i, v);
          chk("R5 qualifier", v, base[i] + (((p == 1) ? f[1] : f[0]) ? 3 : 0));
        end
      end
    end
    priv = 1'b0;
    wr(1, flt(10'h3ff, 10'h3ff));

    // R10 write beats increment
    @(negedge clk); we = 1'b1; addr = AW'(16); wdata = 48'h1234_5678_9ABC; cyc = 1'b1;
    @(negedge clk); we = 1'b0;
    rd(16, v); chk("R10 write priority", v, 48'h1234_5678_9ABC);
    @(negedge clk); cyc = 1'b0;
    rd(16, v); chk("R10 counts after write", v, 48'h1234_5678_9ABD);

    // R6/R7/R8/R9 overflow and interrupt
    wr(2, {16'd0, {4{8'hFF}}}); wr(3, {16'd0, {4{8'hFF}}});
    wr(4, 48'h3FF);
    wr(19, HALF - 2);
    evt[255] = 1'b1; hold(1); evt = '0;
    rd(4, v); chk("R6 no flag before bit 47", v, '0);
    rd(19, v); chk("R6 count value", v, HALF - 1);
    evt[255] = 1'b1; hold(1); evt = '0;
    rd(4, v); chk("R6 flag on bit 47", v, 48'h008);
    rd(19, v); chk("R6 counting continues", v, HALF);
    chk("R8 mode off", {47'd0, irq}, '0);
    hold(3);
    rd(4, v); chk("R7 sticky", v, 48'h008);
    wr(0, ctl(10'h3ff, 10'h008, 2'd1, 1'b0));
    chk("R8 fast irq", {47'd0, irq}, 48'd1);
    hold(1);
    rd(0, v); chk("R9 active set", v, ctl(10'h3ff, 10'h008, 2'd1, 1'b1));
    wr(0, ctl(10'h3ff, 10'h004, 2'd1, 1'b0));
    chk("R8 enable gates", {47'd0, irq}, '0);
    rd(0, v); chk("R9 active cleared", v, ctl(10'h3ff, 10'h004, 2'd1, 1'b0));
    wr(0, ctl(10'h3ff, 10'h008, 2'd2, 1'b0));
    chk("R8 standard mode", {47'd0, irq}, 48'd1);
    wr(4, 48'h004);
    rd(4, v); chk("R7 other bit clear", v, 48'h008);
    wr(4, 48'h008);
    rd(4, v); chk("R7 w1c", v, '0);
    chk("R8 irq drops", {47'd0, irq}, '0);
    wr(0, ctl(10'h3ff, 10'h008, 2'd1, 1'b0));
    hold(2);
    rd(0, v); chk("R9 spurious clear", v, ctl(10'h3ff, 10'h008, 2'd1, 1'b0));
    // R7 set and clear at the same edge
    wr(19, HALF - 1);
    @(negedge clk); we = 1'b1; addr = AW'(4); wdata = 48'h008; evt[255] = 1'b1;
    @(negedge clk); we = 1'b0; evt = '0;
    rd(4, v); chk("R7 set wins", v, 48'h008);
    chk("R8 irq on race", {47'd0, irq}, 48'd1);
    wr(4, 48'h3FF);
    // R8 high group enable
    wr(25, HALF - 1);
    wr(0, ctl(10'h3ff, 10'h100, 2'd1, 1'b0));
    evt[255] = 1'b1; hold(1); evt = '0;
    rd(4, v); chk("R6 high counter flag", v, 48'h200);
    chk("R8 wrong high enable", {47'd0, irq}, '0);
    wr(0, ctl(10'h3ff, 10'h200, 2'd1, 1'b0));
    chk("R8 high enable", {47'd0, irq}, 48'd1);
    wr(0, ctl(10'h3ff, 10'h000, 2'd0, 1'b0));
    wr(4, 48'h3FF);
    // R6 wrap and write do not flag
    wr(20, 48'hFFFF_FFFF_FFFF);
    evt[255] = 1'b1; hold(1); evt = '0;
    rd(20, v); chk("R6 wrap value", v, '0);
    rd(4, v); chk("R6 wrap no flag", v, '0);
    wr(21, HALF);
    rd(4, v); chk("R6 write no flag", v, '0);
    rd(21, v); chk("R10 write readback", v, HALF);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule